// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor's load/store port and a line-wide memory port. It keeps 256 sets of two 16-byte lines (8 KB in total). Each line carries a valid flag, a dirty flag and a 20-bit tag. Each set carries one bit that names the way to be replaced next. The processor presents a 32-bit word request and holds it until the cache answers with a one-cycle ready pulse. A load returns the addressed word with that pulse. A store merges its word into the line.

Hits are served from the internal arrays without any memory traffic. On a miss the cache picks a victim way. If that victim is dirty, it first writes the whole victim line to memory. It then reads the new line. Stores that miss allocate the line and merge the word into it. Memory transfers use a request line that stays high until the memory acknowledges with a one-cycle pulse.

Top module: `cwb_cache`

## Requirements
- R1: Address bits [3:0] are the byte offset in a line, bits [11:4] pick the set and bits [31:12] are the tag. Every memory transfer carries a line address with bits [3:0] equal to zero: the refill uses the request's tag and set, and a write-back uses the victim's stored tag and the same set.
- R2: A load returns word n of the line, where n is address bits [3:2] and word n occupies line bits [32n+31:32n]. The value is always the most recent one stored at that word address.
- R3: A hit makes no memory transfer. Its ready pulse is high in the second cycle after the request is first sampled.
- R4: A store hit replaces the addressed word in the line and marks the line dirty. When that line is later evicted, the write-back carries the stored word.
- R5: On a miss, an invalid way is filled before any valid line is replaced, and way 0 is taken when both ways are invalid. Two different tags in one set therefore both stay resident.
- R6: Each hit or fill sets the set's replacement bit to the other way. When both ways are valid, a miss replaces the way that the bit names.
- R7: A dirty victim is written to memory as the first transfer of the miss, before the refill read. The refill request follows in the cycle after the write acknowledge.
- R8: A clean or invalid victim causes no write-back. The miss makes exactly one refill read.
- R9: A store miss refills the line, merges the store word into it and marks it dirty. The ready pulse comes in the cycle after the refill acknowledge.
- R10: Reset clears every valid, dirty and replacement bit, and drops ready and the memory request. The first access to any address after reset misses.
- R11: Ready is a one-cycle pulse. The memory request, address and direction stay unchanged until the memory acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Line transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Line-aligned address |
| mem_wdata | output | 128 | Write-back line |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 128 | Refill line, valid with mem_ack |

## Verification
A hit's ready pulse is due exactly two rising edges after the request is presented. The bench counts edges at each falling edge until ready appears and compares that count with 2 whenever its own model predicts a hit. A miss has no fixed latency: its ready is due one edge after the refill acknowledge, so the bench records every memory transfer as it grants it. Each operation is then judged on the number, order, address and data of those transfers, and on the returned word sampled at the falling edge where ready is first seen.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOOK,
    S_WBACK,
    S_FILL
  } cwb_state_e;
endpackage

// File: rtl/cwb_line_ram.sv
module cwb_line_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cwb_meta.sv
module cwb_meta #(
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic [1:0]       rd_valid,
  output logic [1:0]       rd_dirty,
  output logic [TAG_W-1:0] rd_tag [2],
  output logic             rd_older,
  input  logic             upd_en,
  input  logic             upd_way,
  input  logic             upd_dirty,
  input  logic [TAG_W-1:0] upd_tag
);
  logic [SETS-1:0] older_q;

  for (genvar w = 0; w < cwb_pkg::WAYS; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel;

    assign sel = upd_en && (upd_way == 1'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (sel) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= upd_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[idx] <= upd_tag;
    end

    assign rd_valid[w] = valid_q[idx];
    assign rd_dirty[w] = dirty_q[idx];
    assign rd_tag[w]   = tag_q[idx];
  end

  // replacement bit names the way to evict next
  always_ff @(posedge clk) begin
    if (rst)         older_q      <= '0;
    else if (upd_en) older_q[idx] <= ~upd_way;
  end

  assign rd_older = older_q[idx];
endmodule

// File: rtl/cwb_way_pick.sv
module cwb_way_pick #(
  parameter int TAG_W = 20
) (
  input  logic [1:0]       valid,
  input  logic [TAG_W-1:0] tags [2],
  input  logic [TAG_W-1:0] req_tag,
  input  logic             older,
  output logic             hit,
  output logic             hit_way,
  output logic             vic_way
);
  logic [1:0] match;

  for (genvar w = 0; w < cwb_pkg::WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == req_tag);
  end

  assign hit     = |match;
  assign hit_way = match[1];
  assign vic_way = !valid[0] ? 1'b0 : (!valid[1] ? 1'b1 : older);
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WSEL_W    = $clog2(LINE_W / WORD_W),
  localparam int BOFF_W    = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  import cwb_pkg::*;

  cwb_state_e        state;
  logic              lat_we;
  logic [ADDR_W-1:0] lat_addr;
  logic [WORD_W-1:0] lat_wdata;
  logic              vic_r;

  logic [IDX_W-1:0]  idx, rd_idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;

  assign idx    = lat_addr[OFF_W +: IDX_W];
  assign tag    = lat_addr[ADDR_W-1 -: TAG_W];
  assign wsel   = lat_addr[BOFF_W +: WSEL_W];
  assign rd_idx = (state == S_IDLE) ? cpu_addr[OFF_W +: IDX_W] : idx;

  logic [1:0]        ram_we;
  logic [LINE_W-1:0] ram_wdata;
  logic [LINE_W-1:0] ram_q [2];

  for (genvar w = 0; w < WAYS; w++) begin : g_ram
    cwb_line_ram #(.DEPTH(SETS), .WIDTH(LINE_W)) u_ram (
      .clk   (clk),
      .we    (ram_we[w]),
      .waddr (idx),
      .wdata (ram_wdata),
      .raddr (rd_idx),
      .rdata (ram_q[w])
    );
  end

  logic [1:0]       m_valid, m_dirty;
  logic [TAG_W-1:0] m_tag [2];
  logic             m_older;
  logic             upd_en, upd_way, upd_dirty;

  cwb_meta #(.SETS(SETS), .TAG_W(TAG_W)) u_meta (
    .clk       (clk),
    .rst       (rst),
    .idx       (idx),
    .rd_valid  (m_valid),
    .rd_dirty  (m_dirty),
    .rd_tag    (m_tag),
    .rd_older  (m_older),
    .upd_en    (upd_en),
    .upd_way   (upd_way),
    .upd_dirty (upd_dirty),
    .upd_tag   (tag)
  );

  logic hit, hit_way, vic_way;

  cwb_way_pick #(.TAG_W(TAG_W)) u_pick (
    .valid   (m_valid),
    .tags    (m_tag),
    .req_tag (tag),
    .older   (m_older),
    .hit     (hit),
    .hit_way (hit_way),
    .vic_way (vic_way)
  );

  // line source for the array write: the refill line or the hit line
  logic [LINE_W-1:0] base_line, merged_line;
  assign base_line = (state == S_FILL) ? mem_rdata : ram_q[hit_way];

  always_comb begin
    merged_line = base_line;
    merged_line[wsel*WORD_W +: WORD_W] = lat_wdata;
  end

  always_comb begin
    ram_we    = '0;
    ram_wdata = lat_we ? merged_line : base_line;
    upd_en    = 1'b0;
    upd_way   = hit_way;
    upd_dirty = 1'b0;
    if (state == S_LOOK && hit) begin
      upd_en          = 1'b1;
      upd_dirty       = m_dirty[hit_way] | lat_we;
      ram_we[hit_way] = lat_we;
    end else if (state == S_FILL && mem_ack) begin
      upd_en        = 1'b1;
      upd_way       = vic_r;
      upd_dirty     = lat_we;
      ram_we[vic_r] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      lat_we    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      vic_r     <= 1'b0;
    end else begin
      cpu_ready <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cpu_req) begin
            lat_we    <= cpu_we;
            lat_addr  <= cpu_addr;
            lat_wdata <= cpu_wdata;
            state     <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= ram_q[hit_way][wsel*WORD_W +: WORD_W];
            state     <= S_IDLE;
          end else begin
            vic_r   <= vic_way;
            mem_req <= 1'b1;
            if (m_valid[vic_way] && m_dirty[vic_way]) begin
              mem_we    <= 1'b1;
              mem_addr  <= {m_tag[vic_way], idx, {OFF_W{1'b0}}};
              mem_wdata <= ram_q[vic_way];
              state     <= S_WBACK;
            end else begin
              mem_we   <= 1'b0;
              mem_addr <= {tag, idx, {OFF_W{1'b0}}};
              state    <= S_FILL;
            end
          end
        end
        S_WBACK: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= {tag, idx, {OFF_W{1'b0}}};
            state    <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= mem_rdata[wsel*WORD_W +: WORD_W];
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwb_cache_chk.sv
module cwb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

  p_quiet_during_mem_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  p_ready_has_req_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> cpu_req);

  p_line_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[OFF_W-1:0] == '0);

  p_done_after_fill_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we && mem_ack |=> cpu_ready && !mem_req);

  p_reset_quiet_r10: assert property (@(posedge clk)
    $fell(rst) |-> !cpu_ready && !mem_req);
endmodule

bind cwb_cache cwb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr)
);

// File: tb/cwb_cache_test.sv
`timescale 1ns/1ps
module cwb_cache_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         cpu_req, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack;
  logic [127:0] mem_rdata;

  always #2 clk = ~clk;

  cwb_cache uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  // backing memory and the latest value of every stored word
  logic [127:0] mem_lines [logic [27:0]];
  logic [31:0]  shadow    [logic [29:0]];

  // reference cache state
  bit          rv [2][256];
  bit          rd [2][256];
  logic [19:0] rt [2][256];
  bit          rl [256];

  int           nrd, nwr;
  bit           wb_first;
  logic [31:0]  wb_addr;
  logic [127:0] wb_data;

  function automatic logic [127:0] init_line(input logic [27:0] la);
    logic [127:0] r;
    for (int i = 0; i < 4; i++)
      r[i*32 +: 32] = (32'(la) * 32'h9E3779B1) ^ (32'h01010101 * 32'(i + 1));
    return r;
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] a);
    logic [127:0] ln;
    if (shadow.exists(a[31:2])) return shadow[a[31:2]];
    ln = mem_lines.exists(a[31:4]) ? mem_lines[a[31:4]] : init_line(a[31:4]);
    return ln[a[3:2]*32 +: 32];
  endfunction

  function automatic logic [127:0] line_of(input logic [27:0] la);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = word_of({la, 2'(i), 2'b00});
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory model: acknowledges each transfer after two cycles
  initial begin
    int lat = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (!rst && mem_req) begin
        lat++;
        if (lat >= 2) begin
          lat = 0;
          if (mem_we) begin
            mem_lines[mem_addr[31:4]] = mem_wdata;
            wb_first = (nrd == 0);
            wb_addr  = mem_addr;
            wb_data  = mem_wdata;
            nwr++;
          end else begin
            mem_rdata = mem_lines.exists(mem_addr[31:4]) ?
                        mem_lines[mem_addr[31:4]] : init_line(mem_addr[31:4]);
            nrd++;
          end
          mem_ack = 1'b1;
        end
      end else lat = 0;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    cpu_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 256; s++) begin
      rv[0][s] = 0; rv[1][s] = 0; rd[0][s] = 0; rd[1][s] = 0; rl[s] = 0;
    end
    shadow.delete();
  endtask

  task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                       output bit was_hit);
    logic [7:0]   s;
    logic [19:0]  tg;
    bit           eh, hw, vic, ewb;
    logic [31:0]  ewb_addr;
    logic [127:0] ewb_line;
    logic [31:0]  ewd;
    int           cyc;
    bit           way;
    s  = a[11:4];
    tg = a[31:12];
    eh = 0; hw = 0;
    if (rv[0][s] && rt[0][s] == tg) begin eh = 1; hw = 0; end
    if (rv[1][s] && rt[1][s] == tg) begin eh = 1; hw = 1; end
    vic = !rv[0][s] ? 1'b0 : (!rv[1][s] ? 1'b1 : rl[s]);
    ewb = !eh && rv[vic][s] && rd[vic][s];
    ewb_addr = {rt[vic][s], s, 4'h0};
    ewb_line = line_of(ewb_addr[31:4]);
    ewd = word_of(a);
    nrd = 0; nwr = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 100);
    chk(cpu_ready, "R11", "ready never came", 0, 1);
    cpu_req = 1'b0;
    if (eh) begin
      chk(cyc == 2, "R3", "hit latency", 128'(cyc), 2);
      chk(nrd + nwr == 0, "R3", "memory traffic on hit", 128'(nrd + nwr), 0);
    end else begin
      chk(nrd == 1, "R6", "refill count on miss", 128'(nrd), 1);
      if (ewb) begin
        chk(nwr == 1, "R7", "dirty victim write-back count", 128'(nwr), 1);
        chk(wb_first, "R7", "write-back before refill", 128'(wb_first), 1);
        chk(wb_addr == ewb_addr, "R1", "write-back address", 128'(wb_addr), 128'(ewb_addr));
        chk(wb_data == ewb_line, "R4", "write-back line", wb_data, ewb_line);
      end else begin
        chk(nwr == 0, "R8", "write-back of clean victim", 128'(nwr), 0);
      end
    end
    if (!we) chk(cpu_rdata == ewd, "R2", "load data", 128'(cpu_rdata), 128'(ewd));
    way = eh ? hw : vic;
    rv[way][s] = 1;
    rt[way][s] = tg;
    rd[way][s] = eh ? (rd[way][s] | we) : we;
    rl[s] = ~way;
    if (we) shadow[a[31:2]] = wd;
    was_hit = eh;
  endtask

  initial begin
    bit h;
    cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    nrd = 0; nwr = 0; wb_first = 0; wb_addr = '0; wb_data = '0;
    do_reset();
    chk(!cpu_ready && !mem_req, "R10", "outputs after reset", {cpu_ready, mem_req}, 0);

    // directed sequence in set 0x00
    do_op(0, 32'h1001_0008, 0, h);
    chk(!h, "R10", "first access after reset hits", 128'(h), 0);
    do_op(0, 32'h2537_1004, 0, h);
    chk(!h && nwr == 0, "R5", "second tag fills empty way", 128'(nwr), 0);
    do_op(0, 32'h1001_0008, 0, h);
    chk(h, "R5", "first tag still resident", 128'(h), 1);
    do_op(0, 32'h2537_1004, 0, h);
    chk(h, "R5", "second tag still resident", 128'(h), 1);
    do_op(1, 32'h1001_000C, 32'hCAFE_0001, h);
    chk(h, "R4", "store hit", 128'(h), 1);
    do_op(0, 32'h1001_000C, 0, h);
    chk(h && cpu_rdata == 32'hCAFE_0001, "R4", "stored word read back", 128'(cpu_rdata), 128'(32'hCAFE_0001));
    do_op(0, 32'h3343_1000, 0, h);
    chk(!h && nwr == 0, "R6", "older clean way replaced", 128'(nwr), 0);
    do_op(0, 32'h2537_1004, 0, h);
    chk(!h && nwr == 1 && wb_addr == 32'h1001_0000, "R7", "dirty older way written back", 128'(wb_addr), 128'(32'h1001_0000));
    do_op(1, 32'h7777_7ff8, 32'hBEEF_0042, h);
    chk(!h && nrd == 1, "R9", "store miss refills", 128'(nrd), 1);
    do_op(0, 32'h7777_7ff8, 0, h);
    chk(h && cpu_rdata == 32'hBEEF_0042, "R9", "allocated store word", 128'(cpu_rdata), 128'(32'hBEEF_0042));
    do_op(0, 32'h7777_7ff4, 0, h);
    chk(h, "R9", "rest of allocated line resident", 128'(h), 1);

    // reset in the middle: nothing stays resident
    do_reset();
    do_op(0, 32'h7777_7ff8, 0, h);
    chk(!h && nwr == 0, "R10", "line lost after reset", 128'(h), 0);

    // constrained random: few tags over few sets to force conflicts
    begin
      logic [19:0] tags [4];
      logic [7:0]  sets [4];
      void'($urandom(32'd1234));
      tags[0] = 20'h10010; tags[1] = 20'h25371; tags[2] = 20'h33431; tags[3] = 20'hFFFFF;
      sets[0] = 8'h00; sets[1] = 8'h01; sets[2] = 8'h7F; sets[3] = 8'hFF;
      for (int n = 0; n < 600; n++) begin
        logic [31:0] a;
        bit w;
        a = {tags[$urandom % 4], sets[$urandom % 4], 2'($urandom % 4), 2'b00};
        w = ($urandom % 10) < 4;
        do_op(w, a, $urandom, h);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule